// File: doc/BRIEF.md
# USB Token Packet Classifier

This block sits after a low-speed USB receiver that has already removed bit stuffing and turned the line into bytes. It watches the byte stream of each packet, and when the receiver marks the end of a packet it decides what the device must do with it. The first byte of a packet is taken as the packet identifier (PID). Data packets go to data handling without any check of the address. Token packets carry a 7-bit device address and the lowest endpoint bit in their second byte, and they are acted on only when that address equals the address that software has programmed.

For each packet of three or more bytes, exactly one registered strobe is raised for one clock: the IN path, the shared SETUP/OUT path, the data path, or the ignore path. Shorter packets are treated as handshakes and pass without a strobe. A current-token register holds the last accepted SETUP or OUT PID with its endpoint bit, so that the data packet that follows can be tied to it. Any ignored packet clears this register. CRC checking and the sending of replies are handled elsewhere.

Top module: `usb_token_sorter`

## Requirements
- R1: After reset all four strobes are low, and `tok_pid` and `tok_ep` are 0.
- R2: A packet that has fewer than 3 bytes at its end raises no strobe and leaves `tok_pid` and `tok_ep` unchanged.
- R3: A packet of 3 or more bytes whose byte 0 is DATA0 (0xC3) or DATA1 (0x4B) raises `data_stb`, whatever its address byte holds. `tok_pid` and `tok_ep` are left unchanged.
- R4: For any other PID, bits 6:0 of byte 1 are the address and bit 7 of byte 1 is the endpoint bit. Bytes are numbered in the order they are received, starting at 0.
- R5: A non-data packet whose address differs from `dev_addr` raises `ignore_stb` and clears `tok_pid` and `tok_ep` to 0.
- R6: An IN packet (0x69) whose address matches raises `in_stb` and loads `tok_ep` with its endpoint bit. `tok_pid` keeps its value.
- R7: A SETUP (0x2D) or OUT (0xE1) packet whose address matches raises `setup_out_stb` and loads `tok_pid` with the PID and `tok_ep` with the endpoint bit.
- R8: Any other PID whose address matches raises `ignore_stb` and clears `tok_pid` and `tok_ep` to 0.
- R9: A strobe goes high in the cycle that follows `rx_eop`, lasts one clock, and never shares that clock with another strobe.
- R10: A byte presented in the same cycle as `rx_eop` counts as the last byte of the packet. Bytes after byte 1 do not change the result.
- R11: The byte count restarts after each `rx_eop`, so a short packet does not add to the length of the packet that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte, in arrival order |
| rx_eop | input | 1 | End of the current packet |
| dev_addr | input | 7 | Programmed device address |
| in_stb | output | 1 | IN token for this device |
| setup_out_stb | output | 1 | SETUP or OUT token for this device |
| data_stb | output | 1 | DATA0 or DATA1 packet |
| ignore_stb | output | 1 | Packet of 3 or more bytes that needs no action |
| tok_pid | output | 8 | Current-token register: last accepted SETUP/OUT PID |
| tok_ep | output | 1 | Endpoint bit held with the current token |

## Verification
Every result comes from a single register stage. The strobes and the token outputs settle on the first rising edge after the `rx_eop` cycle and return to low on the edge after that. The bench drives each cycle's inputs on a falling edge. It checks the strobes and token one falling edge after the `rx_eop` cycle, then checks one edge later that the strobes have dropped again. For short packets it checks at the same point that no strobe rose and that the token did not move.

// File: rtl/usb_token_sorter.sv
module usb_token_sorter #(
  parameter int MIN_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_eop,
  input  logic [6:0] dev_addr,
  output logic       in_stb,
  output logic       setup_out_stb,
  output logic       data_stb,
  output logic       ignore_stb,
  output logic [7:0] tok_pid,
  output logic       tok_ep
);
  localparam int CW = $clog2(MIN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_LEN);
  localparam logic [7:0] PID_OUT = 8'hE1, PID_IN = 8'h69, PID_SETUP = 8'h2D,
                         PID_D0 = 8'hC3, PID_D1 = 8'h4B;

  logic [CW-1:0] cnt, cnt_n;
  logic [7:0]    pid_q, pid_n, adr_q, adr_n;

  assign cnt_n = (rx_vld && cnt != FULL) ? cnt + 1'b1 : cnt;
  assign pid_n = (rx_vld && cnt == '0) ? rx_byte : pid_q;
  assign adr_n = (rx_vld && cnt == CW'(1)) ? rx_byte : adr_q;

  wire long_pkt = (cnt_n == FULL);
  wire is_data  = (pid_n == PID_D0) || (pid_n == PID_D1);
  wire match    = (adr_n[6:0] == dev_addr);
  wire is_in    = (pid_n == PID_IN);
  wire is_so    = (pid_n == PID_SETUP) || (pid_n == PID_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pid_q <= '0;
      adr_q <= '0;
      in_stb <= 1'b0;
      setup_out_stb <= 1'b0;
      data_stb <= 1'b0;
      ignore_stb <= 1'b0;
      tok_pid <= '0;
      tok_ep <= 1'b0;
    end else begin
      in_stb <= 1'b0;
      setup_out_stb <= 1'b0;
      data_stb <= 1'b0;
      ignore_stb <= 1'b0;
      if (rx_eop) begin
        cnt <= '0;
        if (long_pkt) begin
          if (is_data) begin
            data_stb <= 1'b1;
          end else if (match && is_in) begin
            in_stb <= 1'b1;
            tok_ep <= adr_n[7];
          end else if (match && is_so) begin
            setup_out_stb <= 1'b1;
            tok_pid <= pid_n;
            tok_ep <= adr_n[7];
          end else begin
            ignore_stb <= 1'b1;
            tok_pid <= '0;
            tok_ep <= 1'b0;
          end
        end
      end else begin
        cnt <= cnt_n;
        pid_q <= pid_n;
        adr_q <= adr_n;
      end
    end
  end
endmodule

// File: rtl/usb_token_sorter_chk.sv
module usb_token_sorter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_eop,
  input logic       in_stb,
  input logic       setup_out_stb,
  input logic       data_stb,
  input logic       ignore_stb,
  input logic [7:0] tok_pid
);
  wire any_stb = in_stb | setup_out_stb | data_stb | ignore_stb;

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_stb, setup_out_stb, data_stb, ignore_stb}));

  // R9
  strobe_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(rx_eop));

  // R3
  data_keeps_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |-> $stable(tok_pid));

  // R6
  in_keeps_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |-> $stable(tok_pid));

  // R7
  so_loads_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_out_stb |-> (tok_pid == 8'h2D || tok_pid == 8'hE1));

  // R5
  ignore_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_stb |-> (tok_pid == 8'h00));
endmodule

bind usb_token_sorter usb_token_sorter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .in_stb(in_stb),
  .setup_out_stb(setup_out_stb), .data_stb(data_stb),
  .ignore_stb(ignore_stb), .tok_pid(tok_pid)
);

// File: tb/usb_token_sorter_bench.sv
module usb_token_sorter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [3:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [6:0] dev;
    logic [3:0] exp;
  } vec_t;

  // exp bits: {in, setup_out, data, ignore}
  localparam vec_t TBL [NV] = '{
    '{4'd3, 8'h2D, 8'h05, 7'h05, 4'b0100},
    '{4'd3, 8'hC3, 8'h7F, 7'h05, 4'b0010},
    '{4'd3, 8'h69, 8'h85, 7'h05, 4'b1000},
    '{4'd3, 8'hE1, 8'h85, 7'h05, 4'b0100},
    '{4'd3, 8'hE1, 8'h06, 7'h05, 4'b0001},
    '{4'd2, 8'h2D, 8'h05, 7'h05, 4'b0000},
    '{4'd1, 8'hD2, 8'h00, 7'h05, 4'b0000},
    '{4'd3, 8'h4B, 8'h00, 7'h05, 4'b0010},
    '{4'd3, 8'hA5, 8'h05, 7'h05, 4'b0001},
    '{4'd5, 8'h2D, 8'h05, 7'h05, 4'b0100},
    '{4'd3, 8'h69, 8'h05, 7'h05, 4'b1000},
    '{4'd3, 8'hE1, 8'hFF, 7'h7F, 4'b0100}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_vld = 1'b0, rx_eop = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [6:0] dev_addr = 7'h05;
  logic in_stb, setup_out_stb, data_stb, ignore_stb, tok_ep;
  logic [7:0] tok_pid;
  int total = 0, bad = 0;
  logic [7:0] m_pid = '0;
  logic m_ep = 1'b0;
  bit done = 0;

  usb_token_sorter u_usb_token_sorter (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .dev_addr(dev_addr), .in_stb(in_stb),
    .setup_out_stb(setup_out_stb), .data_stb(data_stb),
    .ignore_stb(ignore_stb), .tok_pid(tok_pid), .tok_ep(tok_ep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input int len, input logic [7:0] b0, input logic [7:0] b1,
                      input bit eop_on_last, input logic [3:0] expv,
                      input string req);
    logic [3:0] got;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_vld = 1'b1;
      rx_byte = (i == 0) ? b0 : (i == 1) ? b1 : 8'hAA;
      rx_eop = eop_on_last && (i == len - 1);
    end
    if (!eop_on_last) begin
      @(negedge clk);
      rx_vld = 1'b0;
      rx_eop = 1'b1;
    end
    @(negedge clk);
    rx_vld = 1'b0;
    rx_eop = 1'b0;
    if (expv == 4'b0100) begin m_pid = b0; m_ep = b1[7]; end
    else if (expv == 4'b1000) m_ep = b1[7];
    else if (expv == 4'b0001) begin m_pid = '0; m_ep = 1'b0; end
    got = {in_stb, setup_out_stb, data_stb, ignore_stb};
    chk(got == expv, req, {12'd0, got}, {12'd0, expv});
    chk({tok_pid, tok_ep} == {m_pid, m_ep}, req,
        {7'd0, tok_pid, tok_ep}, {7'd0, m_pid, m_ep});
    @(negedge clk);
    got = {in_stb, setup_out_stb, data_stb, ignore_stb};
    chk(got == 4'b0000, "R9 one-cycle strobe", {12'd0, got}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({in_stb, setup_out_stb, data_stb, ignore_stb, tok_pid, tok_ep} == '0,
        "R1 reset", {3'd0, in_stb, setup_out_stb, data_stb, ignore_stb, tok_pid, tok_ep}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R11
    for (int k = 0; k < NV; k++) begin
      dev_addr = TBL[k].dev;
      send(int'(TBL[k].len), TBL[k].b0, TBL[k].b1, 1'b0, TBL[k].exp,
           $sformatf("R2-R8 vector %0d", k));
    end
    dev_addr = 7'h05;
    // R10 eop together with the third byte
    send(3, 8'h2D, 8'h85, 1'b1, 4'b0100, "R10 eop with last byte");
    // R10 eop together with the second byte: still short
    send(2, 8'hE1, 8'h05, 1'b1, 4'b0000, "R10 short with eop byte");
    // R11 two short packets back to back do not add up
    send(2, 8'h69, 8'h05, 1'b0, 4'b0000, "R11 short a");
    send(1, 8'h69, 8'h05, 1'b0, 4'b0000, "R11 short b");
    // R5 DATA with mismatched address still dispatched (R3), then mismatch IN
    send(3, 8'hC3, 8'h33, 1'b0, 4'b0010, "R3 data any address");
    send(3, 8'h69, 8'h04, 1'b0, 4'b0001, "R5 in mismatch");
    // R1 reset again clears token
    send(3, 8'h2D, 8'h85, 1'b0, 4'b0100, "R7 setup ep1");
    rst_n = 1'b0;
    @(negedge clk);
    chk({tok_pid, tok_ep} == '0, "R1 reset clears token", {7'd0, tok_pid, tok_ep}, 16'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule